// File: doc/BRIEF.md
# Programmable Two-or-Three Clock Divider Cell

This block divides its input clock by two or by three, one division cycle at a time. Identical cells are meant to be chained so that the whole string gives a programmable ratio. Each cell has a local program bit and a mode input that comes back from the next cell down the chain. The cell makes a division cycle one input period longer only when both of these are high. It also passes a reclocked copy of the mode input back to the previous cell.

The cell is modelled with edge-triggered registers on the input clock. Every division cycle ends on a boundary edge. On that edge the cell does three things. It decides the length of the next cycle from the mode input and the program bit. It raises the divided output for one input period. It drives the mode output with the mode input it sampled. Between boundary edges neither input has any effect. A change to the program bit therefore takes effect only from the next division cycle. The base length is a parameter, `BASE_DIV`, with a default of 2. With the default, a long cycle is 3 input periods.

Top module: `divmod23_cell`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `div_out` and `mod_out` are 0 after that edge (synchronous active-high reset).
- R2: After `rst` falls, the first rising edge of `clk` leaves `div_out` at 0. The second rising edge is the first boundary edge and sets `div_out` to 1.
- R3: When `prog` is 0 at a boundary edge, the division cycle that follows lasts 2 input periods, whatever `mod_in` holds.
- R4: When `mod_in` is 0 at a boundary edge, the division cycle that follows lasts 2 input periods, whatever `prog` holds.
- R5: When both `prog` and `mod_in` are 1 at a boundary edge, the division cycle that follows lasts 3 input periods. One extra input period is swallowed.
- R6: `div_out` is 1 for exactly one input period at the start of each division cycle. It is 0 for the rest of that cycle, so it is never high on two edges in a row.
- R7: `prog` and `mod_in` are sampled only at boundary edges. A change to either one during a division cycle does not alter the length of that cycle.
- R8: `mod_out` equals the `mod_in` value sampled at the latest boundary edge, during the one input period in which `div_out` is 1. It is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| prog | input | 1 | Program bit: 1 allows a three-period cycle |
| mod_in | input | 1 | Mode signal returned from the next cell |
| div_out | output | 1 | Divided clock, one period high per division cycle |
| mod_out | output | 1 | Reclocked mode signal sent to the previous cell |

## Verification
The assertions run on every cycle. They check the reset values of both outputs and that the divided output is never high for two periods in a row. They check that the mode output is high only inside the high period of the divided output and that it matches the sampled mode input. They also check that each cycle length follows from the pair of inputs seen at its boundary edge.

Only the bench scenarios can show the exact start-up latency after reset. The same holds for inputs that change in the middle of a cycle and leave that cycle's length alone, and for the program bit toggling across many cycles. The bench's reference model follows these cases on every clock.

// File: rtl/dvc_pkg.sv
package dvc_pkg;

  typedef enum logic {
    LEN_BASE = 1'b0,
    LEN_EXT  = 1'b1
  } len_sel_e;

  function automatic len_sel_e pick_len(input logic prog_bit, input logic mode_bit);
    return (prog_bit && mode_bit) ? LEN_EXT : LEN_BASE;
  endfunction

endpackage

// File: rtl/dvc_phase.sv
module dvc_phase
  import dvc_pkg::*;
#(
  parameter int BASE_DIV = 2,
  parameter int CNT_W    = $clog2(BASE_DIV + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  len_sel_e         len_sel,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(BASE_DIV - 1);
  localparam logic [CNT_W-1:0] LAST_EXT  = CNT_W'(BASE_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_c;

  always_comb begin
    last_c = (len_sel == LEN_EXT) ? LAST_EXT : LAST_BASE;
    wrap   = (cnt_q == last_c);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // the count never runs past the extended cycle end
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_EXT);

endmodule

// File: rtl/dvc_decide.sv
module dvc_decide
  import dvc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wrap,
  input  logic     prog,
  input  logic     mod_in,
  output len_sel_e len_sel
);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_sel <= LEN_BASE;
    end else if (wrap) begin
      len_sel <= pick_len(prog, mod_in);
    end
  end

  // between boundaries the chosen length holds (R7)
  p_len_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(len_sel));

endmodule

// File: rtl/dvc_outreg.sv
module dvc_outreg (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  input  logic mod_in,
  output logic div_out,
  output logic mod_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_out <= 1'b0;
      mod_out <= 1'b0;
    end else begin
      div_out <= wrap;
      mod_out <= wrap & mod_in;
    end
  end

endmodule

// File: rtl/divmod23_cell.sv
module divmod23_cell
  import dvc_pkg::*;
#(
  parameter int BASE_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic prog,
  input  logic mod_in,
  output logic div_out,
  output logic mod_out
);

  localparam int CNT_W = $clog2(BASE_DIV + 1);

  len_sel_e len_sel;
  logic     wrap;

  dvc_phase #(.BASE_DIV(BASE_DIV), .CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .len_sel (len_sel),
    .wrap    (wrap)
  );

  dvc_decide u_decide (
    .clk     (clk),
    .rst     (rst),
    .wrap    (wrap),
    .prog    (prog),
    .mod_in  (mod_in),
    .len_sel (len_sel)
  );

  dvc_outreg u_outreg (
    .clk     (clk),
    .rst     (rst),
    .wrap    (wrap),
    .mod_in  (mod_in),
    .div_out (div_out),
    .mod_out (mod_out)
  );

  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (!div_out && !mod_out));

  p_one_high_r6: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  p_mod_inside_r8: assert property (@(posedge clk) disable iff (rst)
    mod_out |-> div_out);

  p_mod_copy_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(div_out) |-> (mod_out == $past(mod_in)));

  // R3 and R4: a short cycle when either input was low at the boundary
  p_short_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(div_out) && !($past(prog) && $past(mod_in))) |=> !div_out ##1 div_out);

  p_long_r5: assert property (@(posedge clk) disable iff (rst)
    ($rose(div_out) && $past(prog) && $past(mod_in)) |=> !div_out ##1 !div_out ##1 div_out);

endmodule

// File: tb/divmod23_cell_tb.sv
module divmod23_cell_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog = 1'b0;
  logic mod_in = 1'b0;
  logic div_out;
  logic mod_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  int ref_pos = 0;
  int ref_len = 2;
  bit ref_div = 1'b0;
  bit ref_mod = 1'b0;

  always #4 clk = ~clk;

  divmod23_cell u_dut (
    .clk     (clk),
    .rst     (rst),
    .prog    (prog),
    .mod_in  (mod_in),
    .div_out (div_out),
    .mod_out (mod_out)
  );

  always @(posedge clk) begin
    if (rst) begin
      ref_pos = 0;
      ref_len = 2;
      ref_div = 1'b0;
      ref_mod = 1'b0;
    end else if (ref_pos == ref_len - 1) begin
      ref_pos = 0;
      ref_len = (prog && mod_in) ? 3 : 2;
      ref_div = 1'b1;
      ref_mod = mod_in;
    end else begin
      ref_pos = ref_pos + 1;
      ref_div = 1'b0;
      ref_mod = 1'b0;
    end
  end

  // per-cycle comparison against the reference (R6 R8)
  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (div_out !== ref_div) begin
        failures++;
        $display("FAIL R6 div_out actual=%0b expected=%0b t=%0t", div_out, ref_div, $time);
      end
      checks++;
      if (mod_out !== ref_mod) begin
        failures++;
        $display("FAIL R8 mod_out actual=%0b expected=%0b t=%0t", mod_out, ref_mod, $time);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog actual=%0d expected<=50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (div_out !== 1'b1);
  endtask

  task automatic count_to_rise(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (div_out !== 1'b1 && n < 20);
  endtask

  initial begin
    int n;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held low in reset
    check_val("R1 div_out", int'(div_out), 0);
    check_val("R1 mod_out", int'(mod_out), 0);

    // R2: first high two edges after release
    rst = 1'b0;
    @(negedge clk);
    check_val("R2 first edge", int'(div_out), 0);
    @(negedge clk);
    check_val("R2 second edge", int'(div_out), 1);

    // R3: prog low, mod_in high
    prog = 1'b0; mod_in = 1'b1;
    wait_rise();
    for (int i = 0; i < 3; i++) begin
      count_to_rise(n);
      check_val("R3 period", n, 2);
    end

    // R4: mod_in low, prog high
    prog = 1'b1; mod_in = 1'b0;
    wait_rise();
    for (int i = 0; i < 3; i++) begin
      count_to_rise(n);
      check_val("R4 period", n, 2);
    end

    // R5: both high
    prog = 1'b1; mod_in = 1'b1;
    wait_rise();
    for (int i = 0; i < 3; i++) begin
      count_to_rise(n);
      check_val("R5 period", n, 3);
      check_val("R8 mod_out", int'(mod_out), 1);
    end

    // R7: drop mod_in right after a long boundary
    mod_in = 1'b0;
    count_to_rise(n);
    check_val("R7 current cycle kept", n, 3);
    check_val("R8 mod_out low", int'(mod_out), 0);
    count_to_rise(n);
    check_val("R7 next cycle", n, 2);

    // R7: raise prog in mid-cycle, short cycle unaffected
    prog = 1'b0; mod_in = 1'b1;
    wait_rise();
    prog = 1'b1;
    count_to_rise(n);
    check_val("R7 mid change", n, 2);
    count_to_rise(n);
    check_val("R7 after boundary", n, 3);

    // mixed pattern followed by the reference model
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      prog = i[0];
      mod_in = i[1] ^ i[3];
    end

    // R1: reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_val("R1 mid reset div", int'(div_out), 0);
    check_val("R1 mid reset mod", int'(mod_out), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule